// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block combines every reset request on the chip into one internal reset. It also holds the processor core until the oscillator and supply have had time to settle. It runs on the oscillator clock. Five sources can start a reset:

- power-on detection, an active-high level that also acts as an asynchronous clear;
- an active-low external pin;
- a watchdog timeout pulse;
- a power-fail pulse;
- an illegal-address fetch pulse.

The pin is filtered, so a low that is too short is treated as noise. An accepted request sets a hold latch and clears a stabilisation counter. The latch is released when the counter overflows. A new request during the wait starts the full wait again.

After release, a fixed seven-cycle tail follows. The block then issues a two-cycle vector fetch: first the low-byte address, then the high-byte address. The core leaves reset after that fetch. While the core is held, the block drives the initial values of a few control signals: peripheral clock gated off, and a clear for the page register and G flag that also forces the watchdog on and the power-fail detector off.

A cause register records which sources started the most recent reset. Software clears bits in it by writing ones. The block has no path into RAM, so no reset source can alter RAM contents.

Top module: `rstseq_top`

## Requirements
- R1: While `por_req` is high, the block is asynchronously forced into reset: `int_rst`=1, `cpu_hold`=1 and `reset_cause`=5'b00001. The hold wait counts from the first clock edge after `por_req` falls.
- R2: The pin is sampled through a two-flop synchroniser. A reset is accepted only after at least 8 consecutive low samples, and a shorter low leaves `int_rst` and `reset_cause` unchanged.
- R3: While `pin_as_input`=1, lows on `rst_pin_n` of any length cause no reset.
- R4: A one-cycle pulse on `wdt_req`, `pfd_req` or `addr_fail_req` sets `int_rst` at the next clock edge.
- R5: `int_rst` stays high for exactly 2^CNT_W cycles after the last accepted request and then falls. A request during that wait restarts the full wait.
- R6: After `int_rst` falls, exactly 7 cycles pass. Then `vec_fetch` is high for two cycles: `vec_addr`=16'hFFFE in the first (low byte) and 16'hFFFF in the second (high byte).
- R7: From an accepted request until the end of the vector fetch, `cpu_hold`=1, `ctl_init`=1 and `periph_clk_en`=0. Outside that span the values are inverted.
- R8: Each accepted request replaces `reset_cause` with the set of sources active in that cycle. The bit positions are: 0 power-on, 1 pin, 2 watchdog, 3 power-fail, 4 address fail.
- R9: When `cause_clr_we`=1, the bits of `reset_cause` that are set in `cause_clr_mask` are cleared. A request in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_req | input | 1 | Power-on detection level, active high, asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| pin_as_input | input | 1 | Configuration: pin used as a general input, reset disabled |
| wdt_req | input | 1 | Watchdog timeout pulse |
| pfd_req | input | 1 | Power-fail detection pulse |
| addr_fail_req | input | 1 | Illegal-address fetch pulse |
| cause_clr_we | input | 1 | Write strobe for clearing the cause register |
| cause_clr_mask | input | 5 | Write-one-to-clear mask for the cause register |
| int_rst | output | 1 | Internal reset (hold latch output) |
| cpu_hold | output | 1 | Core held, covering the latch, the tail and the vector fetch |
| vec_fetch | output | 1 | Vector fetch strobe, two cycles |
| vec_addr | output | 16 | Address of the vector byte being fetched |
| periph_clk_en | output | 1 | Peripheral clock enable, low while held |
| ctl_init | output | 1 | Clears the page register and G flag, forces the watchdog on and the power-fail detector off |
| reset_cause | output | 5 | Sources of the most recent reset |

## Verification
The hardest situation to reach is a second request arriving partway through the stabilisation wait: the restart has to be visible without the tail ever starting. The bench shortens the counter to a 64-cycle wait, fires a watchdog pulse, and then fires a power-fail pulse 30 cycles later. It confirms the core is still held 40 cycles after the second pulse, which is past the point where the first wait would have ended. A second hard case is a request landing in the same cycle as a cause clear. The bench creates it by driving an address-fail pulse together with an all-ones clear mask.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int NSRC     = 5;
  localparam int SRC_POR  = 0;
  localparam int SRC_PIN  = 1;
  localparam int SRC_WDT  = 2;
  localparam int SRC_PFD  = 3;
  localparam int SRC_ADDR = 4;

  typedef enum logic [2:0] {PH_RUN, PH_HOLD, PH_TAIL, PH_VLO, PH_VHI} phase_t;

  // address of the vector byte: base for low byte, base+1 for high byte
  function automatic logic [15:0] vec_byte_addr(input logic [15:0] base, input logic hi);
    return base + {15'd0, hi};
  endfunction

  // last tail cycle reached
  function automatic logic tail_done(input int unsigned cnt, input int unsigned len);
    return cnt == len - 1;
  endfunction
endpackage

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
  parameter int PIN_MIN = 8
) (
  input  logic clk,
  input  logic por,
  input  logic pin_n,
  input  logic gpio_mode,
  output logic pin_req
);
  localparam int CW = $clog2(PIN_MIN + 1);

  logic          s1, s2;
  logic [CW-1:0] low_cnt;
  logic          filt_low;

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      s1      <= 1'b1;
      s2      <= 1'b1;
      low_cnt <= '0;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
      if (s2)
        low_cnt <= '0;
      else if (low_cnt != CW'(PIN_MIN))
        low_cnt <= low_cnt + 1'b1;
    end
  end

  assign filt_low = (low_cnt == CW'(PIN_MIN));
  assign pin_req  = filt_low & ~gpio_mode;

  // R2: a high synchronised sample withdraws acceptance on the next cycle
  a_r2_high_breaks_run: assert property (@(posedge clk) disable iff (por)
    s2 |=> !filt_low);
endmodule

// File: rtl/rstseq_hold_timer.sv
module rstseq_hold_timer #(
  parameter int CNT_W = 18
) (
  input  logic clk,
  input  logic por,
  input  logic req_any,
  output logic hold_q,
  output logic ovf
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      hold_q <= 1'b1;
      cnt    <= '0;
    end else if (req_any) begin
      hold_q <= 1'b1;
      cnt    <= '0;
    end else if (hold_q) begin
      cnt <= cnt + 1'b1;
      if (cnt == MAXV) hold_q <= 1'b0;
    end
  end

  assign ovf = hold_q & ~req_any & (cnt == MAXV);

  a_r4_req_sets_latch: assert property (@(posedge clk) disable iff (por)
    req_any |=> hold_q && cnt == '0);
  a_r5_hold_before_ovf: assert property (@(posedge clk) disable iff (por)
    hold_q && !ovf |=> hold_q);
  a_r5_release_on_ovf: assert property (@(posedge clk) disable iff (por)
    ovf |=> !hold_q);
endmodule

// File: rtl/rstseq_vector_seq.sv
module rstseq_vector_seq
  import rstseq_pkg::*;
#(
  parameter int          TAIL_CYC = 7,
  parameter logic [15:0] VEC_BASE = 16'hFFFE
) (
  input  logic        clk,
  input  logic        por,
  input  logic        req_any,
  input  logic        ovf,
  output logic        cpu_hold,
  output logic        vec_fetch,
  output logic [15:0] vec_addr
);
  localparam int TCW = $clog2(TAIL_CYC + 1);

  phase_t         ph;
  logic [TCW-1:0] tcnt;
  logic           tail_last;

  assign tail_last = tail_done(32'(tcnt), TAIL_CYC);

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      ph   <= PH_HOLD;
      tcnt <= '0;
    end else if (req_any) begin
      ph   <= PH_HOLD;
      tcnt <= '0;
    end else begin
      case (ph)
        PH_HOLD: if (ovf) begin
          ph   <= PH_TAIL;
          tcnt <= '0;
        end
        PH_TAIL: if (tail_last) ph <= PH_VLO;
                 else tcnt <= tcnt + 1'b1;
        PH_VLO:  ph <= PH_VHI;
        PH_VHI:  ph <= PH_RUN;
        default: ph <= PH_RUN;
      endcase
    end
  end

  assign vec_fetch = (ph == PH_VLO) || (ph == PH_VHI);
  assign cpu_hold  = (ph != PH_RUN);
  assign vec_addr  = vec_byte_addr(VEC_BASE, ph == PH_VHI);

  a_r6_tail_stays: assert property (@(posedge clk) disable iff (por)
    ph == PH_TAIL && !req_any && !tail_last |=> ph == PH_TAIL);
  a_r6_low_then_high: assert property (@(posedge clk) disable iff (por)
    ph == PH_VLO && !req_any |=> vec_fetch && vec_addr == VEC_BASE + 16'd1);
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
  import rstseq_pkg::*;
(
  input  logic            clk,
  input  logic            por,
  input  logic [NSRC-1:0] req_vec,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] cause
);
  logic any_req;
  assign any_req = |req_vec;

  always_ff @(posedge clk or posedge por) begin
    if (por)
      cause <= NSRC'(1) << SRC_POR;
    else if (any_req)
      cause <= req_vec;
    else if (clr_we)
      cause <= cause & ~clr_mask;
  end

  a_r8_cause_load: assert property (@(posedge clk) disable iff (por)
    any_req |=> cause == $past(req_vec));
  a_r9_w1c: assert property (@(posedge clk) disable iff (por)
    clr_we && !any_req |=> (cause & $past(clr_mask)) == '0);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int          CNT_W    = 18,
  parameter int          PIN_MIN  = 8,
  parameter int          TAIL_CYC = 7,
  parameter logic [15:0] VEC_BASE = 16'hFFFE
) (
  input  logic        clk,
  input  logic        por_req,
  input  logic        rst_pin_n,
  input  logic        pin_as_input,
  input  logic        wdt_req,
  input  logic        pfd_req,
  input  logic        addr_fail_req,
  input  logic        cause_clr_we,
  input  logic [4:0]  cause_clr_mask,
  output logic        int_rst,
  output logic        cpu_hold,
  output logic        vec_fetch,
  output logic [15:0] vec_addr,
  output logic        periph_clk_en,
  output logic        ctl_init,
  output logic [4:0]  reset_cause
);
  logic            pin_req;
  logic            req_any;
  logic            ovf;
  logic [NSRC-1:0] req_vec;

  rstseq_pin_filter #(.PIN_MIN(PIN_MIN)) u_pin (
    .clk(clk), .por(por_req), .pin_n(rst_pin_n),
    .gpio_mode(pin_as_input), .pin_req(pin_req));

  always_comb begin
    req_vec           = '0;
    req_vec[SRC_PIN]  = pin_req;
    req_vec[SRC_WDT]  = wdt_req;
    req_vec[SRC_PFD]  = pfd_req;
    req_vec[SRC_ADDR] = addr_fail_req;
  end
  assign req_any = |req_vec;

  rstseq_hold_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .por(por_req), .req_any(req_any),
    .hold_q(int_rst), .ovf(ovf));

  rstseq_vector_seq #(.TAIL_CYC(TAIL_CYC), .VEC_BASE(VEC_BASE)) u_vec (
    .clk(clk), .por(por_req), .req_any(req_any), .ovf(ovf),
    .cpu_hold(cpu_hold), .vec_fetch(vec_fetch), .vec_addr(vec_addr));

  rstseq_cause u_cause (
    .clk(clk), .por(por_req), .req_vec(req_vec),
    .clr_we(cause_clr_we), .clr_mask(cause_clr_mask), .cause(reset_cause));

  assign periph_clk_en = ~cpu_hold;
  assign ctl_init      = cpu_hold;

  a_r7_hold_covers_latch: assert property (@(posedge clk) disable iff (por_req)
    int_rst |-> cpu_hold);
  a_r4_pulse_resets: assert property (@(posedge clk) disable iff (por_req)
    wdt_req || pfd_req || addr_fail_req |=> int_rst);
  a_r3_gpio_no_reset: assert property (@(posedge clk) disable iff (por_req)
    pin_as_input && !wdt_req && !pfd_req && !addr_fail_req && !int_rst |=> !int_rst);
endmodule

// File: tb/rstseq_top_test.sv
module rstseq_top_test;
  localparam int W = 6;

  logic        clk = 1'b0;
  logic        por = 1'b0, pin_n = 1'b1, gpio = 1'b0;
  logic        wdt = 1'b0, pfd = 1'b0, adf = 1'b0, clr = 1'b0;
  logic [4:0]  mask = '0;
  logic        int_rst, cpu_hold, vec_fetch, periph_clk_en, ctl_init;
  logic [15:0] vec_addr;
  logic [4:0]  cause;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit m_en = 0;

  always #10 clk = ~clk;

  rstseq_top #(.CNT_W(W)) uut (
    .clk(clk), .por_req(por), .rst_pin_n(pin_n), .pin_as_input(gpio),
    .wdt_req(wdt), .pfd_req(pfd), .addr_fail_req(adf),
    .cause_clr_we(clr), .cause_clr_mask(mask),
    .int_rst(int_rst), .cpu_hold(cpu_hold), .vec_fetch(vec_fetch),
    .vec_addr(vec_addr), .periph_clk_en(periph_clk_en), .ctl_init(ctl_init),
    .reset_cause(cause));

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // behavioural reference: phase 0 run, 1 latch, 2 tail, 3 vec low, 4 vec high
  bit       m_latch;
  int       m_cnt, m_phase, m_tail;
  bit [4:0] m_cause;
  bit       samp[$];

  task automatic model_por();
    m_latch = 1; m_cnt = 0; m_phase = 1; m_tail = 0; m_cause = 5'b00001;
    samp.delete();
  endtask

  always @(posedge clk) begin
    bit rp, anyr;
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL R5 watchdog expired: actual=%0d expected=<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
    if (por) model_por();
    else begin
      rp = 0;
      if (!gpio && samp.size() >= 10) begin
        rp = 1;
        for (int i = 2; i < 10; i++) if (samp[samp.size()-1-i]) rp = 0;
      end
      anyr = rp | wdt | pfd | adf;
      if (anyr) begin m_phase = 1; m_tail = 0; end
      else case (m_phase)
        1: if (m_latch && m_cnt == (1 << W) - 1) begin m_phase = 2; m_tail = 0; end
        2: if (m_tail == 6) m_phase = 3; else m_tail++;
        3: m_phase = 4;
        4: m_phase = 0;
        default: m_phase = 0;
      endcase
      if (anyr) begin m_latch = 1; m_cnt = 0; end
      else if (m_latch) begin
        if (m_cnt == (1 << W) - 1) begin m_latch = 0; m_cnt = 0; end
        else m_cnt++;
      end
      if (anyr) m_cause = {adf, pfd, wdt, rp, 1'b0};
      else if (clr) m_cause = m_cause & ~mask;
      samp.push_back(pin_n);
    end
  end

  always @(negedge clk) begin
    bit h;
    if (m_en) begin
      if (por) model_por();
      h = (m_phase == 1 || m_phase == 2 || m_phase == 3 || m_phase == 4);
      check("R5 int_rst", int_rst, m_latch);
      check("R7 cpu_hold", cpu_hold, h);
      check("R7 ctl_init", ctl_init, h);
      check("R7 periph_clk_en", periph_clk_en, !h);
      check("R6 vec_fetch", vec_fetch, (m_phase == 3 || m_phase == 4));
      check("R6 vec_addr", vec_addr, (m_phase == 4) ? 16'hFFFF : 16'hFFFE);
      check("R8 reset_cause", cause, m_cause);
    end
  end

  task automatic at_drive(); @(posedge clk); #3; endtask

  task automatic wait_run();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!cpu_hold) break;
    end
  endtask

  initial begin
    #1 por = 1'b1;
    m_en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 int_rst during por", int_rst, 1);
    check("R1 cause during por", cause, 5'b00001);
    at_drive(); por = 1'b0;
    wait_run();
    check("R1 released", int_rst, 0);
    check("R1 cause after por", cause, 5'b00001);

    at_drive(); pin_n = 1'b0;
    repeat (5) @(posedge clk); #3 pin_n = 1'b1;
    repeat (15) @(negedge clk);
    check("R2 short low ignored", int_rst, 0);
    check("R2 cause kept", cause, 5'b00001);

    at_drive(); pin_n = 1'b0;
    repeat (12) @(posedge clk); #3 pin_n = 1'b1;
    @(negedge clk);
    check("R2 long low resets", int_rst, 1);
    check("R8 pin cause", cause, 5'b00010);
    wait_run();

    at_drive(); clr = 1'b1; mask = 5'b00010;
    at_drive(); clr = 1'b0; mask = '0;
    @(negedge clk);
    check("R9 cleared", cause, 5'b00000);

    at_drive(); gpio = 1'b1; pin_n = 1'b0;
    repeat (20) @(posedge clk); #3 pin_n = 1'b1;
    repeat (12) @(negedge clk);
    check("R3 gpio pin int_rst", int_rst, 0);
    check("R3 gpio pin cause", cause, 5'b00000);
    gpio = 1'b0;

    at_drive(); wdt = 1'b1;
    at_drive(); wdt = 1'b0;
    @(negedge clk);
    check("R4 wdt resets", int_rst, 1);
    check("R8 wdt cause", cause, 5'b00100);
    repeat (30) @(negedge clk);
    at_drive(); pfd = 1'b1;
    at_drive(); pfd = 1'b0;
    @(negedge clk);
    check("R4 pfd cause", cause, 5'b01000);
    repeat (40) @(negedge clk);
    check("R5 restarted wait still held", int_rst, 1);
    wait_run();

    at_drive(); adf = 1'b1; clr = 1'b1; mask = 5'b11111;
    at_drive(); adf = 1'b0; clr = 1'b0; mask = '0;
    @(negedge clk);
    check("R9 request beats clear", cause, 5'b10000);
    check("R4 addr fail resets", int_rst, 1);
    wait_run();
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule